// File: doc/BRIEF.md
# Accumulator ALU with Encoded Operations

This block is the arithmetic core of a small single-accumulator processor. It is purely combinational. Each cycle it takes the current accumulator, one general-register operand, the 8-bit immediate byte of the instruction and a group/sub-operation selector, and it returns the next accumulator value. The operations fall into five groups: unary operations on the accumulator, binary operations against the register operand, an unsigned less-than compare, immediate operations, and load-immediate.

The block keeps no flags. A carry out of an add is recovered in software: the sum is compared against one addend with the less-than group, which writes 1 or 0 into the accumulator. A borrow is recovered the same way. The immediate group is packed. Its two low selector bits choose AND, OR or XOR with the byte. The fourth code hands the decision to the byte itself, which then encodes either an add or one of eight bit-indexed operations whose index sits in the low three bits.

All arithmetic wraps modulo 256. The decoder that produces the group and sub-operation codes, the register file and memory belong to the surrounding processor.

Top module: `acc_alu`

## Requirements
- R1: Group 0 (unary) applies to the accumulator the operation chosen by `sub_i`: 0 gives zero, 1 shift left by one, 2 logical shift right by one, 3 arithmetic shift right by one, 4 increment, 5 decrement, 6 ones complement, 7 two's complement negate.
- R2: Group 1 with `sub_i` of 0, 1, 2, 3 or 4 returns the accumulator combined with `reg_i` by add, subtract (accumulator minus register), AND, OR or XOR respectively, wrapping modulo 256.
- R3: Group 1 with `sub_i` of 5, 6 or 7 shifts the accumulator by the count in `reg_i`: 5 is shift left, 6 is logical shift right and 7 is arithmetic shift right. A count of 8 or more gives 0 for the two logical shifts and a full sign fill for the arithmetic shift.
- R4: Group 2 returns 1 when the accumulator is less than `reg_i` as unsigned numbers, and 0 otherwise.
- R5: Group 3 with `sub_i[1:0]` of 00, 01 or 10 returns the accumulator ANDed, ORed or XORed with `imm_i`.
- R6: Group 3 with `sub_i[1:0]` = 11 decodes `imm_i`. When bit 7 is 0, the result is the accumulator plus the 7-bit value in bits 6:0. When bits 7:6 are 11, the result is the accumulator plus the whole byte, which acts as an addend from -64 to -1. Both forms wrap.
- R7: Group 3 with `sub_i[1:0]` = 11 and `imm_i[7:6]` = 10 uses `imm_i[5:3]` as a bit operation and `imm_i[2:0]` as an index n. Operations 0 to 3 rotate left by n, shift left by n, shift right logically by n and shift right arithmetically by n.
- R8: In the same form, operations 4 to 7 act on bit n. 4 clears it, 5 sets it to 1, 6 inverts it, and 7 returns bit n in bit 0 with every other bit cleared.
- R9: Group 4 returns `imm_i` unchanged.
- R10: Groups 5, 6 and 7 return the accumulator unchanged.
- R11: `sub_i[2]` has no effect in group 3. `sub_i` has no effect in groups 2 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Current accumulator value |
| reg_i | input | 8 | General-register operand; also the shift count for group 1 |
| imm_i | input | 8 | Immediate byte of the instruction |
| grp_i | input | 3 | Operation group (0 unary, 1 register, 2 less-than, 3 immediate, 4 load immediate) |
| sub_i | input | 3 | Operation within the group |
| acc_o | output | 8 | Next accumulator value |

## Verification
The assertions take only one thing for granted: that the five inputs are known, two-valued values within their declared widths. Any code is then legal, including the unused groups and shift counts far above the data width, and each assertion is stated as a relation that must hold for every such input. The stimulus does not narrow the encoding space. It sweeps every group and sub-operation code, every immediate byte in the two immediate-driven groups, and, in the other groups, register operands that include counts on both sides of the width limit. For every case it uses accumulator values that include 0x00, 0x7F, 0x80 and 0xFF.

// File: rtl/acc_alu_pkg.sv
// Package acc_alu_pkg
// Shared operation codes for the accumulator ALU. The group codes are the
// values driven on grp_i; the sub-operation codes are the values on sub_i
// (or on the bit-operation field of the immediate byte).
package acc_alu_pkg;

    // operation groups
    localparam logic [2:0] GRP_UNARY = 3'd0;
    localparam logic [2:0] GRP_REG   = 3'd1;
    localparam logic [2:0] GRP_LESS  = 3'd2;
    localparam logic [2:0] GRP_IMM   = 3'd3;
    localparam logic [2:0] GRP_LDI   = 3'd4;

    // unary operations, in selector order
    localparam logic [2:0] U_ZERO = 3'd0;
    localparam logic [2:0] U_SHL1 = 3'd1;
    localparam logic [2:0] U_LSR1 = 3'd2;
    localparam logic [2:0] U_ASR1 = 3'd3;
    localparam logic [2:0] U_INC  = 3'd4;
    localparam logic [2:0] U_DEC  = 3'd5;
    localparam logic [2:0] U_NOT  = 3'd6;
    localparam logic [2:0] U_NEG  = 3'd7;

    // register-operand operations, in selector order
    localparam logic [2:0] R_ADD = 3'd0;
    localparam logic [2:0] R_SUB = 3'd1;
    localparam logic [2:0] R_AND = 3'd2;
    localparam logic [2:0] R_OR  = 3'd3;
    localparam logic [2:0] R_XOR = 3'd4;
    localparam logic [2:0] R_SHL = 3'd5;
    localparam logic [2:0] R_LSR = 3'd6;
    localparam logic [2:0] R_ASR = 3'd7;

    // immediate logic selector (low two bits of sub_i)
    localparam logic [1:0] I_AND = 2'd0;
    localparam logic [1:0] I_OR  = 2'd1;
    localparam logic [1:0] I_XOR = 2'd2;
    localparam logic [1:0] I_EXT = 2'd3;

    // bit operations carried in the immediate byte
    localparam logic [2:0] B_ROL = 3'd0;
    localparam logic [2:0] B_SHL = 3'd1;
    localparam logic [2:0] B_LSR = 3'd2;
    localparam logic [2:0] B_ASR = 3'd3;
    localparam logic [2:0] B_CLR = 3'd4;
    localparam logic [2:0] B_SET = 3'd5;
    localparam logic [2:0] B_TOG = 3'd6;
    localparam logic [2:0] B_EXT = 3'd7;

endpackage

// File: rtl/acc_unary_unit.sv
// Module acc_unary_unit
// Applies one of eight single-operand operations to the accumulator.
// Assumes: purely combinational, no clock or reset; results wrap modulo 2**W.
module acc_unary_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc_i,
    input  logic [2:0]   sel_i,
    output logic [W-1:0] res_o
);
    import acc_alu_pkg::*;

    // select the unary result and guard the negate path
    always_comb begin
        case (sel_i)
            U_ZERO:  res_o = '0;
            U_SHL1:  res_o = {acc_i[W-2:0], 1'b0};
            U_LSR1:  res_o = {1'b0, acc_i[W-1:1]};
            U_ASR1:  res_o = {acc_i[W-1], acc_i[W-1:1]};
            U_INC:   res_o = acc_i + 1'b1;
            U_DEC:   res_o = acc_i - 1'b1;
            U_NOT:   res_o = ~acc_i;
            default: res_o = '0 - acc_i;
        endcase
        if (sel_i == U_NEG) begin
            AST_NEG_SUMS_TO_ZERO: assert (W'(res_o + acc_i) == '0); // R1
        end
        if (sel_i == U_INC) begin
            AST_INC_ONE_ABOVE: assert (W'(res_o - acc_i) == W'(1)); // R1
        end
    end
endmodule

// File: rtl/acc_reg_unit.sv
// Module acc_reg_unit
// Combines the accumulator with a register operand (arithmetic, logic and
// shifts by a register count) and forms the unsigned less-than result.
// Assumes: purely combinational; a count of W or more shifts every bit out.
module acc_reg_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opr_i,
    input  logic [2:0]   sel_i,
    output logic [W-1:0] res_o,
    output logic [W-1:0] less_o
);
    import acc_alu_pkg::*;

    logic count_over;

    // flag shift counts that empty the accumulator
    always_comb count_over = (opr_i >= W[W-1:0]) || (W > (1 << W));

    // select the register-operand result
    always_comb begin
        case (sel_i)
            R_ADD:   res_o = acc_i + opr_i;
            R_SUB:   res_o = acc_i - opr_i;
            R_AND:   res_o = acc_i & opr_i;
            R_OR:    res_o = acc_i | opr_i;
            R_XOR:   res_o = acc_i ^ opr_i;
            R_SHL:   res_o = count_over ? '0 : (acc_i << opr_i);
            R_LSR:   res_o = count_over ? '0 : (acc_i >> opr_i);
            default: res_o = count_over ? {W{acc_i[W-1]}}
                                        : W'($signed(acc_i) >>> opr_i);
        endcase
        if (sel_i == R_SUB) begin
            AST_SUB_UNDOES_ADD: assert (W'(res_o + opr_i) == acc_i); // R2
        end
        if (sel_i == R_ASR && acc_i[W-1] == 1'b0) begin
            AST_ASR_NO_GROWTH: assert (res_o <= acc_i); // R3
        end
    end

    // unsigned compare, result 0 or 1 in the accumulator width
    always_comb begin
        less_o = {{(W-1){1'b0}}, (acc_i < opr_i)};
        if (acc_i == opr_i) begin
            AST_LESS_EQUAL_IS_ZERO: assert (less_o == '0); // R4
        end
        if (opr_i == '0) begin
            AST_LESS_NOTHING_BELOW_ZERO: assert (less_o == '0); // R4
        end
    end
endmodule

// File: rtl/acc_imm_unit.sv
// Module acc_imm_unit
// Immediate operations: AND/OR/XOR with the byte, or, for the extended
// selector, an add or a bit-indexed operation decoded from the byte itself.
// Assumes: W is 8 so the byte layout (2-bit kind, 3-bit op, 3-bit index)
// fills the immediate exactly; purely combinational.
module acc_imm_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] imm_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] res_o
);
    import acc_alu_pkg::*;

    localparam int IW = $clog2(W);

    logic [1:0]    kind;
    logic [2:0]    bop;
    logic [IW-1:0] idx;
    logic [W-1:0]  mask;
    logic [W-1:0]  short_add;
    logic [W-1:0]  long_add;
    logic [W-1:0]  bit_res;

    // split the immediate byte into its fields
    always_comb begin
        kind = imm_i[W-1:W-2];
        bop  = imm_i[IW+2:IW];
        idx  = imm_i[IW-1:0];
        mask = W'(1) << idx;
    end

    // the two add forms of the extended group
    always_comb begin
        short_add = acc_i + {1'b0, imm_i[W-2:0]};
        long_add  = acc_i + imm_i;
    end

    // bit-indexed operations on index idx
    always_comb begin
        case (bop)
            B_ROL:   bit_res = W'((acc_i << idx) | (acc_i >> (W - int'(idx))));
            B_SHL:   bit_res = acc_i << idx;
            B_LSR:   bit_res = acc_i >> idx;
            B_ASR:   bit_res = W'($signed(acc_i) >>> idx);
            B_CLR:   bit_res = acc_i & ~mask;
            B_SET:   bit_res = acc_i | mask;
            B_TOG:   bit_res = acc_i ^ mask;
            default: bit_res = {{(W-1){1'b0}}, acc_i[idx]};
        endcase
        if (bop == B_EXT) begin
            AST_EXTRACT_SINGLE_BIT: assert (bit_res[W-1:1] == '0); // R8
        end
        if (bop == B_TOG) begin
            AST_TOGGLE_ONE_BIT: assert ($onehot(bit_res ^ acc_i)); // R8
        end
        if (bop == B_ROL) begin
            AST_ROTATE_KEEPS_ONES: assert ($countones(bit_res) == $countones(acc_i)); // R7
        end
    end

    // choose between logic, add and bit results
    always_comb begin
        case (sel_i)
            I_AND:   res_o = acc_i & imm_i;
            I_OR:    res_o = acc_i | imm_i;
            I_XOR:   res_o = acc_i ^ imm_i;
            default: begin
                if (!imm_i[W-1])       res_o = short_add;
                else if (imm_i[W-2])   res_o = long_add;
                else                   res_o = bit_res;
            end
        endcase
        if (sel_i == I_EXT && kind == 2'b11) begin
            AST_LONG_ADD_DIFF: assert (W'(res_o - acc_i) == imm_i); // R6
        end
        if (sel_i == I_EXT && kind[1] == 1'b0) begin
            AST_SHORT_ADD_DIFF: assert (W'(res_o - acc_i) == {1'b0, imm_i[W-2:0]}); // R6
        end
    end
endmodule

// File: rtl/acc_alu.sv
// Module acc_alu
// Top of the accumulator ALU: runs the unary, register and immediate units
// in parallel and selects the next accumulator by operation group.
// Assumes: purely combinational, no clock or reset; unused groups hold the
// accumulator. Carries are recovered by software through the less-than group.
module acc_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] reg_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic [2:0]        grp_i,
    input  logic [2:0]        sub_i,
    output logic [DATA_W-1:0] acc_o
);
    import acc_alu_pkg::*;

    logic [DATA_W-1:0] unary_res;
    logic [DATA_W-1:0] reg_res;
    logic [DATA_W-1:0] less_res;
    logic [DATA_W-1:0] imm_res;

    acc_unary_unit #(.W(DATA_W)) unary_i (
        .acc_i (acc_i),
        .sel_i (sub_i),
        .res_o (unary_res)
    );

    acc_reg_unit #(.W(DATA_W)) regop_i (
        .acc_i  (acc_i),
        .opr_i  (reg_i),
        .sel_i  (sub_i),
        .res_o  (reg_res),
        .less_o (less_res)
    );

    acc_imm_unit #(.W(DATA_W)) immop_i (
        .acc_i (acc_i),
        .imm_i (imm_i),
        .sel_i (sub_i[1:0]),
        .res_o (imm_res)
    );

    // pick the next accumulator by group
    always_comb begin
        case (grp_i)
            GRP_UNARY: acc_o = unary_res;
            GRP_REG:   acc_o = reg_res;
            GRP_LESS:  acc_o = less_res;
            GRP_IMM:   acc_o = imm_res;
            GRP_LDI:   acc_o = imm_i;
            default:   acc_o = acc_i;
        endcase
        if (grp_i > GRP_LDI) begin
            AST_UNUSED_GROUP_HOLDS: assert (acc_o == acc_i); // R10
        end
        if (grp_i == GRP_LESS) begin
            AST_LESS_ZERO_OR_ONE: assert (acc_o[DATA_W-1:1] == '0); // R4
        end
    end
endmodule

// File: tb/acc_alu_tb_top.sv
// Bench acc_alu_tb_top
// Near-exhaustive sweep of every group and sub-operation code against an
// arithmetic model written from the requirements.
module acc_alu_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_i = '0;
    logic [7:0] reg_i = '0;
    logic [7:0] imm_i = '0;
    logic [2:0] grp_i = '0;
    logic [2:0] sub_i = '0;
    logic [7:0] acc_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    acc_alu #(.DATA_W(8)) dut_i (
        .acc_i (acc_i),
        .reg_i (reg_i),
        .imm_i (imm_i),
        .grp_i (grp_i),
        .sub_i (sub_i),
        .acc_o (acc_o)
    );

    function automatic int pw2(int n);
        return 1 << n;
    endfunction

    // arithmetic shift right of an 8-bit value, floor division on signed view
    function automatic int asr8(int a, int n);
        int sa;
        int d;
        if (n >= 8) return (a >= 128) ? 255 : 0;
        sa = (a >= 128) ? a - 256 : a;
        d  = pw2(n);
        if (sa >= 0) sa = sa / d;
        else         sa = -((-sa + d - 1) / d);
        return (sa + 256) % 256;
    endfunction

    function automatic int bitwise(int a, int b, int kind);
        int r = 0;
        for (int k = 0; k < 8; k++) begin
            int x = (a / pw2(k)) % 2;
            int y = (b / pw2(k)) % 2;
            int z;
            if (kind == 0)      z = x * y;
            else if (kind == 1) z = (x + y > 0) ? 1 : 0;
            else                z = (x + y) % 2;
            r = r + z * pw2(k);
        end
        return r;
    endfunction

    function automatic int model(int g, int s, int a, int r, int m);
        int n;
        int op;
        int b;
        case (g)
            0: case (s)
                0: return 0;
                1: return (a * 2) % 256;
                2: return a / 2;
                3: return a / 2 + ((a >= 128) ? 128 : 0);
                4: return (a + 1) % 256;
                5: return (a + 255) % 256;
                6: return 255 - a;
                default: return (256 - a) % 256;
            endcase
            1: case (s)
                0: return (a + r) % 256;
                1: return (a - r + 256) % 256;
                2: return bitwise(a, r, 0);
                3: return bitwise(a, r, 1);
                4: return bitwise(a, r, 2);
                5: return (r >= 8) ? 0 : (a * pw2(r)) % 256;
                6: return (r >= 8) ? 0 : a / pw2(r);
                default: return asr8(a, r);
            endcase
            2: return (a < r) ? 1 : 0;
            3: begin
                if (s % 4 < 3) return bitwise(a, m, s % 4);
                if (m < 128) return (a + m) % 256;
                if (m >= 192) return (a + m) % 256;
                op = (m / 8) % 8;
                n  = m % 8;
                b  = (a / pw2(n)) % 2;
                case (op)
                    0: return (a * pw2(n) + a / pw2(8 - n)) % 256;
                    1: return (a * pw2(n)) % 256;
                    2: return a / pw2(n);
                    3: return asr8(a, n);
                    4: return a - b * pw2(n);
                    5: return a + (1 - b) * pw2(n);
                    6: return (b == 1) ? a - pw2(n) : a + pw2(n);
                    default: return b;
                endcase
            end
            4: return m;
            default: return a;
        endcase
    endfunction

    function automatic string req_of(int g, int s, int m);
        if (g == 0) return "R1";
        if (g == 1) return (s < 5) ? "R2" : "R3";
        if (g == 2) return (s != 0) ? "R11" : "R4";
        if (g == 3) begin
            if (s >= 4) return "R11";
            if (s < 3) return "R5";
            if (m < 128 || m >= 192) return "R6";
            return (((m / 8) % 8) < 4) ? "R7" : "R8";
        end
        if (g == 4) return (s != 0) ? "R11" : "R9";
        return "R10";
    endfunction

    function automatic int acc_pick(int k);
        case (k)
            0: return 8'h00;
            1: return 8'h7F;
            2: return 8'h80;
            3: return 8'hFF;
            4: return 8'h01;
            5: return 8'h5A;
            6: return 8'hA5;
            default: return 8'hC3;
        endcase
    endfunction

    function automatic int reg_pick(int k);
        if (k < 12) return k;
        if (k == 12) return 8'h7F;
        if (k == 13) return 8'h80;
        if (k == 14) return 8'hFF;
        return (k * 37 + 11) % 256;
    endfunction

    task automatic apply_check(int g, int s, int a, int r, int m);
        int exp;
        @(posedge clk);
        #1;
        grp_i = g[2:0];
        sub_i = s[2:0];
        acc_i = a[7:0];
        reg_i = r[7:0];
        imm_i = m[7:0];
        @(negedge clk);
        exp = model(g, s, a, r, m);
        n_checks++;
        if (acc_o !== exp[7:0]) begin
            n_fail++;
            $display("FAIL %s grp=%0d sub=%0d acc=%02h reg=%02h imm=%02h actual=%02h expected=%02h",
                     req_of(g, s, m), g, s, a, r, m, acc_o, exp[7:0]);
        end
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    // stimulus and checks
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // state after reset: an unused group passes the accumulator (R10)
        apply_check(5, 0, 8'h3C, 0, 0);
        // load immediate with edge bytes (R9)
        apply_check(4, 0, 8'h12, 0, 8'h80);
        for (int g = 0; g < 8; g++) begin
            for (int s = 0; s < 8; s++) begin
                if (g == 3 || g == 4) begin
                    for (int ak = 0; ak < 8; ak++)
                        for (int m = 0; m < 256; m++)
                            apply_check(g, s, acc_pick(ak), reg_pick((m + ak) % 32), m);
                end else begin
                    for (int ak = 0; ak < 8; ak++)
                        for (int rk = 0; rk < 32; rk++)
                            apply_check(g, s, acc_pick(ak), reg_pick(rk), (rk * 91 + ak) % 256);
                end
            end
        end
        // carry recovery: sum below an addend means carry out (R4)
        apply_check(2, 0, 8'h10, 8'hF8, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule